// File: doc/BRIEF.md
# Four/Five-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads one 64-bit entry from each level of an in-memory tree of page tables. Each table has 512 entries, and each level consumes 9 virtual-address bits. A depth control selects the walk depth at run time:

- four levels, translating virtual address bits 47:0;
- five levels, translating bits 56:0.

The depth control lives at bit 12 of a control register. It can only be written while the processor is outside 64-bit operation, and it only takes effect while the processor is in 64-bit operation.

A request carries a virtual address. The root table is given as a frame number. The walker first checks canonical form: every address bit above the highest translated bit must copy that bit. A request that fails this check is answered at once with a fault and no memory traffic. Otherwise the walker issues one read at a time on a ready/valid memory port. A table entry whose present flag is clear ends the walk with a fault that names the level. A successful walk returns the leaf frame joined with the page offset. The result stays valid until it is acknowledged.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, `mem_req_valid` is 0 and `mode_o` is 0.
- R2: A control write (`ctl_wr_en` high) loads `ctl_wr_data[12]` into `mode_o` when `long_mode` is 0. When `long_mode` is 1 the write is ignored and `mode_o` keeps its value.
- R3: A walk uses five levels only when `mode_o` is 1 and `long_mode` is 1 at acceptance. Otherwise it uses four levels.
- R4: In four-level walks, a virtual address whose bits 63:48 are not all equal to bit 47 completes with `res_cause`=1, `res_level`=0 and no memory read.
- R5: In five-level walks, a virtual address whose bits 63:57 are not all equal to bit 56 completes with `res_cause`=1, `res_level`=0 and no memory read.
- R6: Reads proceed from the top level (5 or 4) down to level 1. The level-L index is va[12+9(L-1)+8 : 12+9(L-1)]. Each read address is table_frame·4096 + index·8. The first table frame is `root_frame`; each later one is the previous entry's bits 51:12.
- R7: A successful walk issues exactly 4 reads in four-level mode and 5 in five-level mode.
- R8: An entry with bit 0 clear ends the walk with no further reads, `res_cause`=2, and `res_level` set to the level of that entry.
- R9: On success, `res_cause`=0 and `res_paddr` = {12'b0, leaf entry[51:12], va[11:0]}.
- R10: A request is accepted only while `req_ready` is high (idle). `res_valid` and the result fields hold until `res_ack`. `mem_req_addr` holds while a read waits for `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| long_mode | input | 1 | Processor is in 64-bit operation |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 64 | Control write data, depth bit at 12 |
| mode_o | output | 1 | Current depth control bit |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| root_frame | input | 40 | Frame number of the top table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 64 | Byte address of entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| res_valid | output | 1 | Result valid |
| res_ack | input | 1 | Result acknowledge |
| res_paddr | output | 64 | Physical address |
| res_cause | output | 2 | 0 ok, 1 non-canonical, 2 not present |
| res_level | output | 3 | Level of not-present fault |

## Verification
The bench targets the canonical boundary in both depths. One address is valid for five levels but non-canonical for four. A design that used a single sign boundary would either fault on the good one or read memory for the bad one.

Not-present entries are planted at level 5, level 3 and the leaf. A walker that kept reading after a clear present flag, or that reported the wrong level, shows up in the logged read addresses.

The depth bit is exercised in three ways:
- written while in 64-bit operation, which must leave it unchanged;
- set while outside 64-bit operation, which must still give a four-level walk;
- read back through `mode_o`.

Memory-ready stalls check that a held read keeps its address.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W    = 64;
  localparam int PA_W    = 52;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int ESZ_LG  = 3;
  localparam int FRM_W   = PA_W - OFF_W;
  localparam int LVL_W   = 3;
  localparam int LVL4    = 4;
  localparam int LVL5    = 5;
  localparam int TOP4    = OFF_W + LVL4 * IDX_W - 1;
  localparam int TOP5    = OFF_W + LVL5 * IDX_W - 1;
  localparam int MODE_BIT = 12;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NONCANON = 2'd1,
    CAUSE_ABSENT   = 2'd2
  } cause_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} st_e;

  function automatic logic is_canonical(logic [VA_W-1:0] va, logic five);
    logic signed [VA_W-1:0] hi;
    hi = $signed(va) >>> (five ? TOP5 : TOP4);
    return (hi == '0) || (hi == '1);
  endfunction

  function automatic logic [IDX_W-1:0] lvl_index(logic [VA_W-1:0] va, logic [LVL_W-1:0] lvl);
    int lo;
    lo = (lvl == '0) ? OFF_W : OFF_W + IDX_W * (int'(lvl) - 1);
    return va[lo +: IDX_W];
  endfunction

  function automatic logic [VA_W-1:0] entry_addr(logic [FRM_W-1:0] frm, logic [IDX_W-1:0] idx);
    return {{(VA_W-PA_W){1'b0}}, frm, idx, {ESZ_LG{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] leaf_paddr(logic [FRM_W-1:0] frm, logic [VA_W-1:0] va);
    return {{(VA_W-PA_W){1'b0}}, frm, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pgwalk_mode.sv
module pgwalk_mode
  import pgwalk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            long_mode,
  input  logic            ctl_wr_en,
  input  logic [VA_W-1:0] ctl_wr_data,
  output logic            mode_q,
  output logic            five_eff
);
  logic wr_allowed;
  assign wr_allowed = ctl_wr_en && !long_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= 1'b0;
    else if (wr_allowed) mode_q <= ctl_wr_data[MODE_BIT];
  end

  assign five_eff = mode_q && long_mode;

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    long_mode |=> $stable(mode_q)); // R2
  AST_MODE_FOUR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !long_mode |-> !five_eff); // R3
endmodule

// File: rtl/pgwalk_canon.sv
module pgwalk_canon
  import pgwalk_pkg::*;
(
  input  logic [VA_W-1:0]  chk_va,
  input  logic             chk_five,
  output logic             noncanon,
  input  logic [VA_W-1:0]  walk_va,
  input  logic [LVL_W-1:0] walk_lvl,
  output logic [IDX_W-1:0] walk_idx
);
  assign noncanon = !is_canonical(chk_va, chk_five);
  assign walk_idx = lvl_index(walk_va, walk_lvl);
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             five_eff,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [FRM_W-1:0] root_frame,
  input  logic             noncanon,
  output logic [VA_W-1:0]  va_q,
  output logic [LVL_W-1:0] lvl_q,
  input  logic [IDX_W-1:0] walk_idx,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [VA_W-1:0]  mem_rsp_data,
  output logic             res_valid,
  input  logic             res_ack,
  output logic [VA_W-1:0]  res_paddr,
  output logic [1:0]       res_cause,
  output logic [LVL_W-1:0] res_level
);
  st_e              st;
  logic [FRM_W-1:0] frm_q;
  logic             five_q;
  cause_e           cause_q;

  logic accept, rd_fire, rsp_take, rsp_absent;
  assign accept     = req_valid && (st == ST_IDLE);
  assign rd_fire    = mem_req_valid && mem_req_ready;
  assign rsp_take   = (st == ST_WAIT) && mem_rsp_valid;
  assign rsp_absent = rsp_take && !mem_rsp_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      frm_q     <= '0;
      five_q    <= 1'b0;
      va_q      <= '0;
      lvl_q     <= '0;
      cause_q   <= CAUSE_NONE;
      res_level <= '0;
      res_paddr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          va_q      <= req_vaddr;
          five_q    <= five_eff;
          frm_q     <= root_frame;
          lvl_q     <= five_eff ? LVL_W'(LVL5) : LVL_W'(LVL4);
          res_level <= '0;
          res_paddr <= '0;
          if (noncanon) begin
            cause_q <= CAUSE_NONCANON;
            st      <= ST_DONE;
          end else begin
            cause_q <= CAUSE_NONE;
            st      <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (rd_fire) st <= ST_WAIT;
        ST_WAIT: if (rsp_take) begin
          if (rsp_absent) begin
            cause_q   <= CAUSE_ABSENT;
            res_level <= lvl_q;
            st        <= ST_DONE;
          end else if (lvl_q == LVL_W'(1)) begin
            res_paddr <= leaf_paddr(mem_rsp_data[PA_W-1:OFF_W], va_q);
            st        <= ST_DONE;
          end else begin
            frm_q <= mem_rsp_data[PA_W-1:OFF_W];
            lvl_q <= lvl_q - LVL_W'(1);
            st    <= ST_ISSUE;
          end
        end
        ST_DONE: if (res_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign mem_req_addr  = entry_addr(frm_q, walk_idx);
  assign res_valid     = (st == ST_DONE);
  assign res_cause     = cause_q;

  AST_NONCANON_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    accept && noncanon |=> res_valid && !mem_req_valid); // R4
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (lvl_q != '0) && (lvl_q <= (five_q ? LVL_W'(LVL5) : LVL_W'(LVL4)))); // R7
  AST_ABSENT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_absent |=> res_valid && res_cause == CAUSE_ABSENT && !mem_req_valid); // R8
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ack |=> res_valid && $stable(res_paddr) && $stable(res_cause)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid && !res_valid); // R1
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              long_mode,
  input  logic              ctl_wr_en,
  input  logic [63:0]       ctl_wr_data,
  output logic              mode_o,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic [39:0]       root_frame,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [63:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              res_valid,
  input  logic              res_ack,
  output logic [63:0]       res_paddr,
  output logic [1:0]        res_cause,
  output logic [2:0]        res_level
);
  logic             five_eff, noncanon;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;
  logic [IDX_W-1:0] walk_idx;

  pgwalk_mode u_mode (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .mode_q(mode_o), .five_eff(five_eff)
  );

  pgwalk_canon u_canon (
    .chk_va(req_vaddr), .chk_five(five_eff), .noncanon(noncanon),
    .walk_va(va_q), .walk_lvl(lvl_q), .walk_idx(walk_idx)
  );

  pgwalk_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .five_eff(five_eff),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .root_frame(root_frame), .noncanon(noncanon),
    .va_q(va_q), .lvl_q(lvl_q), .walk_idx(walk_idx),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ack(res_ack),
    .res_paddr(res_paddr), .res_cause(res_cause), .res_level(res_level)
  );
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [63:0] ctl_wr_data = '0;
  logic        mode_o;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [39:0] root_frame = 40'h00_1234_5000;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ack = 1'b0;
  logic [63:0] res_paddr;
  logic [1:0]  res_cause;
  logic [2:0]  res_level;

  always #10 clk = ~clk;

  pgwalk_top dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit stall = 1'b0;
  logic [63:0] rd_log [8];
  int n_rd = 0;

  function automatic logic [63:0] mem_entry(logic [63:0] a);
    logic [39:0] frm;
    frm = {a[27:3], a[51:37]} ^ 40'h5A_A55A_3C3C;
    return {12'h000, frm, 11'h000, (a[11:3] != 9'h1FF)};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_entry(mem_req_addr);
      if (n_rd < 8) rd_log[n_rd] <= mem_req_addr;
      n_rd <= n_rd + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    mem_req_ready <= stall ? ~mem_req_ready : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end

  task automatic set_mode(input bit m, input bit lm);
    @(negedge clk);
    long_mode = 1'b0; ctl_wr_en = 1'b1; ctl_wr_data = 64'(m) << 12;
    @(negedge clk);
    ctl_wr_en = 1'b0; long_mode = lm;
  endtask

  task automatic reference(input logic [63:0] va, input bit five,
      output logic [1:0] cause, output logic [2:0] lvl, output logic [63:0] pa,
      output int nrd, output logic [63:0] addrs [8]);
    logic [63:0] base, e, a, hi;
    int top;
    cause = 0; lvl = 0; pa = 0; nrd = 0;
    for (int k = 0; k < 8; k++) addrs[k] = '0;
    top = five ? 5 : 4;
    hi = va >> (five ? 56 : 47);
    if (!(hi == 0 || hi == (64'hFFFF_FFFF_FFFF_FFFF >> (five ? 56 : 47)))) begin
      cause = 1;
      return;
    end
    base = {24'h0, root_frame} * 64'd4096;
    for (int L = top; L >= 1; L--) begin
      a = base + ((va >> (12 + 9 * (L - 1))) & 64'd511) * 64'd8;
      addrs[nrd] = a; nrd++;
      e = mem_entry(a);
      if (!e[0]) begin cause = 2; lvl = 3'(L); return; end
      base = e & 64'h000F_FFFF_FFFF_F000;
    end
    pa = base | (va & 64'hFFF);
  endtask

  task automatic run_walk(input logic [63:0] va, output logic [1:0] c, output logic [2:0] l,
      output logic [63:0] p);
    int w;
    @(negedge clk);
    n_rd = 0; req_vaddr = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!res_valid && w < 200) begin @(negedge clk); w++; end
    c = res_cause; l = res_level; p = res_paddr;
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
  endtask

  localparam int NV = 12;
  localparam logic [63:0] VA_T [NV] = '{
    64'h0000_1234_5678_9ABC, 64'hFFFF_8000_0000_0123, 64'h0000_8000_0000_0000,
    64'h00AB_CDEF_0123_4567, 64'h00AB_CDEF_0123_4567, 64'h0100_0000_0000_0000,
    64'hFF80_0000_0000_0000, 64'h0000_0000_001F_F000, 64'hFFFF_0000_0000_0000,
    64'h0000_007F_C000_0000, 64'h0000_1234_5678_9ABC, 64'h0100_0000_0000_0000};
  localparam logic [1:0] MODE_T [NV] = '{2'b01, 2'b01, 2'b01, 2'b11, 2'b01, 2'b11,
                                         2'b11, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10};
  localparam logic [1:0] CAUSE_T [NV] = '{0, 0, 1, 0, 1, 1, 0, 2, 2, 2, 0, 1};
  localparam logic [2:0] LVL_T [NV]   = '{0, 0, 0, 0, 0, 0, 0, 1, 5, 3, 0, 0};
  localparam int         NRD_T [NV]   = '{4, 4, 0, 5, 0, 0, 5, 4, 1, 2, 4, 0};

  initial begin
    logic [1:0]  c, ec;
    logic [2:0]  l, el;
    logic [63:0] p, ep;
    int          enr;
    logic [63:0] eaddr [8];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1 && res_valid == 0 && mem_req_valid == 0 && mode_o == 0, "R1 reset",
          {res_valid, mem_req_valid, mode_o, req_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      set_mode(MODE_T[i][1], MODE_T[i][0]);
      stall = i[0];
      reference(VA_T[i], MODE_T[i] == 2'b11, ec, el, ep, enr, eaddr);
      run_walk(VA_T[i], c, l, p);
      // R4 R5 R8 cause and level; R3 depth under mode and long_mode
      check(c == CAUSE_T[i] && ec == CAUSE_T[i], "R3/R4/R5/R8 cause", 64'(c), 64'(CAUSE_T[i]));
      check(l == LVL_T[i], "R8 level", 64'(l), 64'(LVL_T[i]));
      // R7 read count
      check(n_rd == NRD_T[i] && enr == NRD_T[i], "R7 reads", 64'(n_rd), 64'(NRD_T[i]));
      // R6 read addresses
      for (int k = 0; k < NRD_T[i]; k++)
        check(rd_log[k] == eaddr[k], "R6 address", rd_log[k], eaddr[k]);
      // R9 physical address
      if (CAUSE_T[i] == 0) check(p == ep, "R9 paddr", p, ep);
    end
    stall = 1'b0;

    // R2 write ignored in 64-bit operation
    set_mode(1'b1, 1'b1);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_data = 64'h0;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    @(negedge clk);
    check(mode_o == 1'b1, "R2 locked write", 64'(mode_o), 64'h1);
    // R2 write honored outside, takes only bit 12
    long_mode = 1'b0;
    ctl_wr_en = 1'b1; ctl_wr_data = 64'hFFFF_FFFF_FFFF_EFFF;
    @(negedge clk);
    ctl_wr_en = 1'b0;
    check(mode_o == 1'b0, "R2 open write", 64'(mode_o), 64'h0);

    // R10 hold without ack, busy refuses requests
    long_mode = 1'b1;
    @(negedge clk);
    req_vaddr = 64'h0000_1234_5678_9ABC; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b0, "R10 busy", 64'(req_ready), 64'h0);
    while (!res_valid && cycles < 90000) @(negedge clk);
    req_valid = 1'b0;
    p = res_paddr;
    repeat (5) @(negedge clk);
    check(res_valid == 1'b1 && res_paddr == p, "R10 hold", res_paddr, p);
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    check(res_valid == 1'b0 && req_ready == 1'b1, "R10 ack", 64'(res_valid), 64'h0);

    finish_run();
  end
endmodule